// File: doc/BRIEF.md
# Vital Product Data Capability Access Controller

This block is the configuration-space face of a product-information store. It exposes two 32-bit words. The first word holds a constant capability identifier, a constant link to the next capability, a 15-bit storage address and a completion flag. The second word is a 32-bit data window. Host software starts a four-byte transfer by writing the address half of the first word. The flag it writes selects the direction of the transfer.

The block then runs a single request/acknowledge exchange with a backing storage device, which is usually a serial memory behind its own engine. It reports completion by changing the flag. A read starts with the flag at 0, and the block sets the flag to 1 once the fetched word sits in the data window. A write starts with the flag at 1, and the block clears it once storage has taken the word.

Software polls the flag and never sees an explicit busy bit. For this reason, address writes made while a transfer is pending are dropped, and the data window is frozen against host writes during that time.

Top module: `vpd_cap_ctrl`

## Requirements
- R1: Word 0 bits [7:0] always read 8'h03 and bits [15:8] always read the NEXT_PTR parameter (8'h00 marks the end of the list). Host writes to those two byte lanes change nothing and start no transfer.
- R2: After reset the flag (word 0 bit 31) is 0, the address field (word 0 bits [30:16]) is 0, the data window (word 1) is 0 and no storage request is raised.
- R3: While idle, a host write to word 0 with byte strobe 3 set captures bits [30:16] as the address and bit 31 as the flag. With bit 31 at 0 it raises a read request (st_we low) on the next cycle.
- R4: When storage acknowledges a read, the data window takes st_rdata, the flag reads 1 from the next cycle, and the request drops.
- R5: A host write to word 0 with byte strobe 3 set and bit 31 at 1 raises a write request whose st_wdata is the data window's content.
- R6: When storage acknowledges a write, the flag reads 0 from the next cycle, and the request drops.
- R7: A storage request stays asserted with st_addr, st_we and st_wdata unchanged until st_ack is seen.
- R8: st_addr is the stored address with its two low bits forced to 0. The address field reads back exactly as written.
- R9: While a transfer is pending, host writes to word 0 are ignored. The address, the flag and the request are unaffected.
- R10: While idle, host writes to word 1 update only the bytes whose strobe is set. While a transfer is pending, such writes are ignored.
- R11: The data window changes only through an idle host write or a read acknowledge. A write acknowledge leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Host write strobe |
| cfg_sel | input | 1 | Word select: 0 header/address word, 1 data window |
| cfg_wstrb | input | 4 | Byte lane strobes for host writes |
| cfg_wdata | input | 32 | Host write data |
| cfg_rdata | output | 32 | Read data of the selected word (combinational) |
| st_req | output | 1 | Storage request, held until acknowledged |
| st_we | output | 1 | Request direction: 1 write, 0 read |
| st_addr | output | 15 | Four-byte aligned storage address |
| st_wdata | output | 32 | Word to be written to storage |
| st_ack | input | 1 | Storage acknowledge, one cycle |
| st_rdata | input | 32 | Storage read data, valid with st_ack |

## Verification
The storage responder varies its latency, and a scoreboard confirms that every request carries the expected direction, aligned address and write word. A design that lets a second address write restart the engine mid-transfer would emit an extra or altered request, or show a changed address or flag. A design that lets host data writes through during a transfer would either corrupt the outgoing word or end up with the host value instead of the fetched one. The flag is checked to move in opposite directions for reads and writes. A design that sets the flag on a write acknowledge, or that reloads the data window on one, is caught.

// File: rtl/vpd_pkg.sv
package vpd_pkg;

    localparam int VPD_WORD_W   = 32;
    localparam int VPD_BYTE_W   = 8;
    localparam int VPD_ALIGN_W  = 2;
    localparam logic [7:0] VPD_CAP_ID = 8'h03;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_READ  = 2'd1,
        XF_WRITE = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/vpd_xfer_fsm.sv
module vpd_xfer_fsm
    import vpd_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_wr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_flag,
    input  logic              st_ack,
    output logic              busy,
    output logic              flag,
    output logic [ADDR_W-1:0] addr,
    output logic              st_req,
    output logic              st_we,
    output logic [ADDR_W-1:0] st_addr,
    output logic              rd_load
);

    typedef struct packed {
        xfer_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic              flag;
    } fsm_regs_t;

    fsm_regs_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            XF_IDLE: begin
                if (hdr_wr) begin
                    d.addr = wr_addr;
                    d.flag = wr_flag;
                    d.st   = wr_flag ? XF_WRITE : XF_READ;
                end
            end
            XF_READ: begin
                if (st_ack) begin
                    d.flag = 1'b1;
                    d.st   = XF_IDLE;
                end
            end
            XF_WRITE: begin
                if (st_ack) begin
                    d.flag = 1'b0;
                    d.st   = XF_IDLE;
                end
            end
            default: d.st = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= XF_IDLE;
            q.addr <= '0;
            q.flag <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != XF_IDLE);
    assign flag    = q.flag;
    assign addr    = q.addr;
    assign st_req  = busy;
    assign st_we   = (q.st == XF_WRITE);
    assign st_addr = {q.addr[ADDR_W-1:VPD_ALIGN_W], {VPD_ALIGN_W{1'b0}}};
    assign rd_load = (q.st == XF_READ) && st_ack;

endmodule

// File: rtl/vpd_data_reg.sv
module vpd_data_reg
    import vpd_pkg::*;
#(
    parameter int DATA_W = VPD_WORD_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         busy,
    input  logic                         host_wr,
    input  logic [DATA_W/VPD_BYTE_W-1:0] host_strb,
    input  logic [DATA_W-1:0]            host_data,
    input  logic                         rd_load,
    input  logic [DATA_W-1:0]            rd_data,
    output logic [DATA_W-1:0]            data
);

    localparam int LANES = DATA_W / VPD_BYTE_W;

    logic [DATA_W-1:0]     data_d, data_q;
    logic [VPD_BYTE_W-1:0] lane_nxt [LANES];
    logic                  host_ok;

    assign host_ok = host_wr && !busy;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (rd_load)
                lane_nxt[g] = rd_data[g*VPD_BYTE_W +: VPD_BYTE_W];
            else if (host_ok && host_strb[g])
                lane_nxt[g] = host_data[g*VPD_BYTE_W +: VPD_BYTE_W];
            else
                lane_nxt[g] = data_q[g*VPD_BYTE_W +: VPD_BYTE_W];
        end
    end

    always_comb begin
        data_d = data_q;
        for (int i = 0; i < LANES; i++)
            data_d[i*VPD_BYTE_W +: VPD_BYTE_W] = lane_nxt[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign data = data_q;

endmodule

// File: rtl/vpd_cfg_rmux.sv
module vpd_cfg_rmux
    import vpd_pkg::*;
#(
    parameter int         ADDR_W   = 15,
    parameter logic [7:0] NEXT_PTR = 8'h00
) (
    input  logic                  sel,
    input  logic                  flag,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [VPD_WORD_W-1:0] data,
    output logic [VPD_WORD_W-1:0] rdata
);

    always_comb begin
        if (sel) rdata = data;
        else     rdata = {flag, addr, NEXT_PTR, VPD_CAP_ID};
    end

endmodule

// File: rtl/vpd_cap_ctrl.sv
module vpd_cap_ctrl
    import vpd_pkg::*;
#(
    parameter int         ADDR_W   = 15,
    parameter logic [7:0] NEXT_PTR = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [3:0]        cfg_wstrb,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              st_req,
    output logic              st_we,
    output logic [ADDR_W-1:0] st_addr,
    output logic [31:0]       st_wdata,
    input  logic              st_ack,
    input  logic [31:0]       st_rdata
);

    localparam int ADDR_LSB = 16;
    localparam int FLAG_BIT = VPD_WORD_W - 1;

    logic              hdr_wr, data_wr, busy_w, flag_w, rd_load_w;
    logic [ADDR_W-1:0] addr_w;
    logic [31:0]       data_w;

    assign hdr_wr  = cfg_we && !cfg_sel && cfg_wstrb[3];
    assign data_wr = cfg_we && cfg_sel;

    vpd_xfer_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hdr_wr  (hdr_wr),
        .wr_addr (cfg_wdata[ADDR_LSB +: ADDR_W]),
        .wr_flag (cfg_wdata[FLAG_BIT]),
        .st_ack  (st_ack),
        .busy    (busy_w),
        .flag    (flag_w),
        .addr    (addr_w),
        .st_req  (st_req),
        .st_we   (st_we),
        .st_addr (st_addr),
        .rd_load (rd_load_w)
    );

    vpd_data_reg #(.DATA_W(VPD_WORD_W)) data_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy_w),
        .host_wr   (data_wr),
        .host_strb (cfg_wstrb),
        .host_data (cfg_wdata),
        .rd_load   (rd_load_w),
        .rd_data   (st_rdata),
        .data      (data_w)
    );

    vpd_cfg_rmux #(.ADDR_W(ADDR_W), .NEXT_PTR(NEXT_PTR)) rmux_i (
        .sel   (cfg_sel),
        .flag  (flag_w),
        .addr  (addr_w),
        .data  (data_w),
        .rdata (cfg_rdata)
    );

    assign st_wdata = data_w;

endmodule

// File: rtl/vpd_cap_ctrl_chk.sv
module vpd_cap_ctrl_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_sel,
    input logic              st_req,
    input logic              st_we,
    input logic [ADDR_W-1:0] st_addr,
    input logic [31:0]       st_wdata,
    input logic              st_ack,
    input logic [31:0]       st_rdata,
    input logic              flag,
    input logic [31:0]       data
);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && !st_ack |=> st_req);

    // R7
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && !st_ack |=> $stable(st_addr) && $stable(st_we) && $stable(st_wdata));

    // R8
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |-> st_addr[1:0] == 2'b00);

    // R4
    rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && st_ack && !st_we |=> flag && !st_req && data == $past(st_rdata));

    // R6
    wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && st_ack && st_we |=> !flag && !st_req);

    // R9
    busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && !st_ack |=> $stable(flag));

    // R11
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_sel) && !(st_req && st_ack && !st_we) |=> $stable(data));

endmodule

bind vpd_cap_ctrl vpd_cap_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .st_req   (st_req),
    .st_we    (st_we),
    .st_addr  (st_addr),
    .st_wdata (st_wdata),
    .st_ack   (st_ack),
    .st_rdata (st_rdata),
    .flag     (flag_w),
    .data     (data_w)
);

// File: tb/vpd_cap_ctrl_tb.sv
module vpd_cap_ctrl_tb_top;

    localparam int         AW   = 15;
    localparam logic [7:0] NEXT = 8'h5C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [3:0]  cfg_wstrb = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        st_req, st_we;
    logic [AW-1:0] st_addr;
    logic [31:0] st_wdata;
    logic        st_ack = 1'b0;
    logic [31:0] st_rdata = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int lat_force = -1;
    int lat_rot = 0;

    typedef struct { logic we; logic [AW-1:0] addr; logic [31:0] wdata; } item_t;
    item_t exp_q[$];
    logic [31:0] mem [int];

    always #2 clk = ~clk;

    vpd_cap_ctrl #(.ADDR_W(AW), .NEXT_PTR(NEXT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wstrb(cfg_wstrb), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .st_req(st_req), .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata),
        .st_ack(st_ack), .st_rdata(st_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_rd(input int a);
        if (mem.exists(a)) return mem[a];
        return 32'hC3A50000 ^ (a * 32'h0001_0011);
    endfunction

    // monitor and storage responder: pops the scoreboard at each acknowledge
    initial begin
        forever begin
            @(negedge clk);
            if (st_req) begin
                int lat;
                item_t e;
                lat = (lat_force >= 0) ? lat_force : lat_rot;
                lat_rot = (lat_rot + 1) % 4;
                repeat (lat) @(negedge clk);
                check(st_req === 1'b1, "R7 request held", {31'b0, st_req}, 32'h1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected request", {17'b0, st_addr}, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(st_we === e.we, "R3/R5 direction", {31'b0, st_we}, {31'b0, e.we});
                    check(st_addr === e.addr, "R8 storage address", {17'b0, st_addr}, {17'b0, e.addr});
                    if (e.we)
                        check(st_wdata === e.wdata, "R5 write word", st_wdata, e.wdata);
                end
                if (st_we) mem[int'(st_addr)] = st_wdata;
                st_rdata = mem_rd(int'(st_addr));
                st_ack = 1'b1;
                @(negedge clk);
                st_ack = 1'b0;
            end
        end
    end

    task automatic cfg_write(input logic sel, input logic [3:0] strb, input logic [31:0] d);
        @(negedge clk);
        cfg_sel = sel; cfg_wstrb = strb; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wstrb = '0;
    endtask

    task automatic cfg_read(input logic sel, output logic [31:0] d);
        @(negedge clk);
        cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_flag(input logic val, input string req);
        logic [31:0] r;
        int n = 0;
        do begin
            cfg_read(1'b0, r);
            n++;
        end while (r[31] !== val && n < 60);
        check(r[31] === val, req, {31'b0, r[31]}, {31'b0, val});
    endtask

    task automatic push(input logic we, input logic [AW-1:0] a, input logic [31:0] wd);
        item_t e;
        e.we = we; e.addr = {a[AW-1:2], 2'b00}; e.wdata = wd;
        exp_q.push_back(e);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, dv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 / R1 reset state and header constants
        cfg_read(1'b0, r);
        check(r === {16'h0000, NEXT, 8'h03}, "R1 R2 header after reset", r, {16'h0000, NEXT, 8'h03});
        cfg_read(1'b1, r);
        check(r === 32'h0, "R2 data window after reset", r, 32'h0);
        check(st_req === 1'b0, "R2 no request after reset", {31'b0, st_req}, 32'h0);

        // R1 header lanes are read-only and start nothing
        cfg_write(1'b0, 4'b0011, 32'h0000_FFFF);
        repeat (3) @(negedge clk);
        check(st_req === 1'b0, "R1 header write starts nothing", {31'b0, st_req}, 32'h0);
        cfg_read(1'b0, r);
        check(r === {16'h0000, NEXT, 8'h03}, "R1 header unchanged", r, {16'h0000, NEXT, 8'h03});

        // R3 R4 read
        push(1'b0, 15'h0010, 32'h0);
        cfg_write(1'b0, 4'b1100, {1'b0, 15'h0010, 16'h0});
        cfg_read(1'b0, r);
        check(r[30:16] === 15'h0010, "R3 address captured", {17'b0, r[30:16]}, 32'h10);
        wait_flag(1'b1, "R4 read sets flag");
        cfg_read(1'b1, r);
        check(r === mem_rd(32'h10), "R4 data window loaded", r, mem_rd(32'h10));

        // R10 R5 R6 R11 write
        cfg_write(1'b1, 4'b1111, 32'h1234_5678);
        cfg_read(1'b1, r);
        check(r === 32'h1234_5678, "R10 idle data write", r, 32'h1234_5678);
        push(1'b1, 15'h0024, 32'h1234_5678);
        cfg_write(1'b0, 4'b1100, {1'b1, 15'h0024, 16'h0});
        wait_flag(1'b0, "R6 write clears flag");
        check(mem_rd(32'h24) === 32'h1234_5678, "R5 storage written", mem_rd(32'h24), 32'h1234_5678);
        cfg_read(1'b1, r);
        check(r === 32'h1234_5678, "R11 data kept after write ack", r, 32'h1234_5678);

        // R4 read back the stored word
        push(1'b0, 15'h0024, 32'h0);
        cfg_write(1'b0, 4'b1100, {1'b0, 15'h0024, 16'h0});
        wait_flag(1'b1, "R4 read after write");
        cfg_read(1'b1, r);
        check(r === 32'h1234_5678, "R4 read returns written word", r, 32'h1234_5678);

        // R8 unaligned address
        push(1'b0, 15'h0107, 32'h0);
        cfg_write(1'b0, 4'b1100, {1'b0, 15'h0107, 16'h0});
        wait_flag(1'b1, "R8 unaligned read completes");
        cfg_read(1'b0, r);
        check(r[30:16] === 15'h0107, "R8 address reads back as written", {17'b0, r[30:16]}, 32'h107);
        cfg_read(1'b1, r);
        check(r === mem_rd(32'h104), "R8 aligned word fetched", r, mem_rd(32'h104));

        // R9 R10 writes while busy are ignored
        lat_force = 8;
        push(1'b0, 15'h0200, 32'h0);
        cfg_write(1'b0, 4'b1100, {1'b0, 15'h0200, 16'h0});
        cfg_write(1'b0, 4'b1100, {1'b1, 15'h0300, 16'h0});
        cfg_write(1'b1, 4'b1111, 32'hDEAD_BEEF);
        cfg_read(1'b0, r);
        check(r[31:16] === {1'b0, 15'h0200}, "R9 busy address write ignored", {16'b0, r[31:16]}, 32'h0200);
        wait_flag(1'b1, "R9 original read completes");
        cfg_read(1'b1, r);
        check(r === mem_rd(32'h200), "R10 busy data write ignored", r, mem_rd(32'h200));
        repeat (4) @(negedge clk);
        check(st_req === 1'b0 && exp_q.size() == 0, "R9 no extra request", {31'b0, st_req}, 32'h0);
        lat_force = -1;

        // R10 byte lanes
        dv = mem_rd(32'h200);
        cfg_write(1'b1, 4'b0101, 32'hAABB_CCDD);
        cfg_read(1'b1, r);
        check(r === {dv[31:24], 8'hBB, dv[15:8], 8'hDD}, "R10 byte lane write", r, {dv[31:24], 8'hBB, dv[15:8], 8'hDD});

        // R5 write started with strobe 3 only
        dv = {dv[31:24], 8'hBB, dv[15:8], 8'hDD};
        push(1'b1, 15'h0040, dv);
        cfg_write(1'b0, 4'b1000, {1'b1, 15'h0040, 16'h0});
        wait_flag(1'b0, "R5 lane3 write completes");
        check(mem_rd(32'h40) === dv, "R5 lane3 write stored", mem_rd(32'h40), dv);

        check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 32'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule